// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A cycle-accurate, synthesizable model of a pipelined synchronous burst memory with a 36-bit word split into four 9-bit byte lanes and a small parameterised depth. Every synchronous input is captured by an input register on the rising clock edge. A cycle opens when either of two address strobes is seen: a processor strobe that is gated by the pipelined chip enable, or a controller strobe that is always honoured. The opening edge latches the start address and the state of all three chip enables. After that, an advance input steps a 2-bit burst counter that produces the next word address in interleaved or linear order.

Reads travel through an array read register and a registered output stage. The first word of a burst therefore appears three clock edges after its command, and each advanced word follows one edge later. Writes are self-timed: address, data and lane mask are registered and committed one edge later with no further handshake. The output enable gates the valid flag combinationally, and one deselecting cycle idles the output in its own pipeline slot.

Top module: `sbsram`

## Requirements
- R1: After reset `rvalid_o` is 0. A read issued before rising edge n shows its data on `rdata_o`, with `rvalid_o` high, after edge n+2 (three edges). An advanced read issued one cycle later shows after edge n+3.
- R2: Address and chip-enable inputs are used only on a strobe cycle. During a burst, the values on `addr_i` and the chip enables in advance cycles do not change which word is accessed.
- R3: The burst counter steps only in a cycle with `adv_i` high. A cycle with no strobe and no advance performs no access, leaves `rvalid_o` low in its output slot, and the next advance continues from the held position.
- R4: With `lin_i` = 0 (interleaved), the low two address bits of burst word k are the start value XOR k. The upper address bits stay at the captured start.
- R5: With `lin_i` = 1 (linear), the low two address bits of burst word k are (start + k) mod 4, and the upper bits stay fixed.
- R6: In a write cycle with `wr_all_i` = 0, lane j (bits 9j+8 down to 9j) of the addressed word is written only if `lane_wen_i` and `lane_we_i[j]` are both 1. The other lanes keep their contents.
- R7: `wr_all_i` = 1 writes all four lanes, whatever the lane enables are.
- R8: `oe_i` = 0 forces `rvalid_o` to 0 without waiting for a clock edge, and the held data reappears when `oe_i` returns to 1.
- R9: A strobe cycle in which any of `cs_pipe_i`, `cs_hi_i`, `cs_lo_i` is 0 deselects the part. That slot gives no read output and no write, and the advance cycles that follow are ignored until the next selecting strobe.
- R10: `astb_cpu_i` is ignored while `cs_pipe_i` is 0. `astb_ctl_i` still opens a cycle in that case and samples all three enables.
- R11: A cycle opened by the processor strobe (with `cs_pipe_i` = 1) is a read even if write controls are asserted. The write controls are honoured in the advance cycles that follow it.
- R12: A read issued in the cycle right after a write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address, latched on strobe cycles |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| cs_pipe_i | input | 1 | Pipelined chip enable, active high |
| cs_hi_i | input | 1 | Depth-expansion enable, active high |
| cs_lo_i | input | 1 | Second depth-expansion enable, active high |
| astb_cpu_i | input | 1 | Processor address strobe, gated by cs_pipe_i |
| astb_ctl_i | input | 1 | Controller address strobe |
| adv_i | input | 1 | Advance the burst counter |
| lane_we_i | input | 4 | Per-lane write enables |
| lane_wen_i | input | 1 | Enables the per-lane writes |
| wr_all_i | input | 1 | Global write of all lanes |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_i | input | 1 | Asynchronous output enable |
| rdata_o | output | 36 | Read data from the output register |
| rvalid_o | output | 1 | Read data valid, 0 when disabled or idle |

## Verification
A wrong burst counter or start latch shows up at the output as a wrong word in the first advanced slot, three edges after the advance is issued. This error repeats on every later word of that burst. A lost or extra write stays hidden until that word is read back, so the bench fills the array and keeps reading random addresses, which brings a stale lane into view within a few dozen cycles. A slip in pipeline depth or deselect handling turns every following slot into a valid-flag mismatch at once.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    typedef struct packed {
        logic             cpu;
        logic             ctl;
        logic             adv;
        logic             ce_a;
        logic             ce_b;
        logic             ce_c;
        logic             bwe;
        logic             gw;
        logic             lin;
        logic [LANES-1:0] lane_we;
    } cmd_t;

    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       lin);
        return lin ? (start + step) : (start ^ step);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input cmd_t c);
        if (c.gw)
            return {LANES{1'b1}};
        else if (c.bwe)
            return c.lane_we;
        else
            return '0;
    endfunction

endpackage

// File: rtl/sbs_in_reg.sv
module sbs_in_reg
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_d,
    input  logic [AW-1:0]     adr_d,
    input  logic [WORD_W-1:0] din_d,
    output cmd_t              cmd_q,
    output logic [AW-1:0]     adr_q,
    output logic [WORD_W-1:0] din_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            adr_q <= '0;
            din_q <= '0;
        end else begin
            cmd_q <= cmd_d;
            adr_q <= adr_d;
            din_q <= din_d;
        end
    end

endmodule

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd_q,
    input  logic [AW-1:0]    adr_q,
    output op_e              op_o,
    output logic [AW-1:0]    acc_adr_o,
    output logic [LANES-1:0] wmask_o
);

    logic          act_q, act_d;
    logic [AW-1:0] base_q, base_d;
    logic [1:0]    cnt_q, cnt_d;
    logic          cpu_ok, start_c, sel_c;
    logic [LANES-1:0] mask_c;

    always_comb begin
        cpu_ok  = cmd_q.cpu & cmd_q.ce_a;
        start_c = cpu_ok | cmd_q.ctl;
        sel_c   = cmd_q.ce_a & cmd_q.ce_b & cmd_q.ce_c;
        mask_c  = lane_mask(cmd_q);
        act_d   = act_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        op_o    = OP_NONE;
        if (start_c) begin
            act_d  = sel_c;
            base_d = adr_q;
            cnt_d  = 2'd0;
            if (sel_c)
                op_o = (cpu_ok || mask_c == '0) ? OP_RD : OP_WR;
        end else if (cmd_q.adv && act_q) begin
            cnt_d = cnt_q + 2'd1;
            op_o  = (mask_c == '0) ? OP_RD : OP_WR;
        end
        acc_adr_o = {base_d[AW-1:2], burst_low(base_d[1:0], cnt_d, cmd_q.lin)};
        wmask_o   = (op_o == OP_WR) ? mask_c : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            act_q  <= act_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    a_r3_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (!start_c && !cmd_q.adv) |=> $stable(cnt_q));

    a_r5_base_fixed: assert property (@(posedge clk) disable iff (rst)
        (!start_c) |=> $stable(base_q));

    a_r9_desel: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.ctl && !cmd_q.ce_b) |=> !act_q);

    a_r10_cpu_gate: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.cpu && !cmd_q.ce_a && !cmd_q.ctl && !cmd_q.adv) |-> (op_o == OP_NONE));

endmodule

// File: rtl/sbs_array.sv
module sbs_array
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_i,
    input  logic [AW-1:0]     adr_i,
    input  logic [LANES-1:0]  wmask_i,
    input  logic [WORD_W-1:0] din_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rd_vld_o
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (op_i == OP_WR && wmask_i[l])
                mem[adr_i] <= din_i[l*LANE_W +: LANE_W];
            if (op_i == OP_RD)
                rd_data_o[l*LANE_W +: LANE_W] <= mem[adr_i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_vld_o <= 1'b0;
        else
            rd_vld_o <= (op_i == OP_RD);
    end

endmodule

// File: rtl/sbsram.sv
module sbsram
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr_i,
    input  logic [35:0]       wdata_i,
    input  logic              cs_pipe_i,
    input  logic              cs_hi_i,
    input  logic              cs_lo_i,
    input  logic              astb_cpu_i,
    input  logic              astb_ctl_i,
    input  logic              adv_i,
    input  logic [3:0]        lane_we_i,
    input  logic              lane_wen_i,
    input  logic              wr_all_i,
    input  logic              lin_i,
    input  logic              oe_i,
    output logic [35:0]       rdata_o,
    output logic              rvalid_o
);

    cmd_t              cmd_d, cmd_q;
    logic [AW-1:0]     adr_q, acc_adr;
    logic [WORD_W-1:0] din_q, arr_data, out_q;
    op_e               op;
    logic [LANES-1:0]  wmask;
    logic              arr_vld, out_vld_q;

    always_comb begin
        cmd_d.cpu     = astb_cpu_i;
        cmd_d.ctl     = astb_ctl_i;
        cmd_d.adv     = adv_i;
        cmd_d.ce_a    = cs_pipe_i;
        cmd_d.ce_b    = cs_hi_i;
        cmd_d.ce_c    = cs_lo_i;
        cmd_d.bwe     = lane_wen_i;
        cmd_d.gw      = wr_all_i;
        cmd_d.lin     = lin_i;
        cmd_d.lane_we = lane_we_i;
    end

    sbs_in_reg #(.AW(AW)) u_in (
        .clk(clk), .rst(rst),
        .cmd_d(cmd_d), .adr_d(addr_i), .din_d(wdata_i),
        .cmd_q(cmd_q), .adr_q(adr_q), .din_q(din_q)
    );

    sbs_burst_ctl #(.AW(AW)) u_ctl (
        .clk(clk), .rst(rst),
        .cmd_q(cmd_q), .adr_q(adr_q),
        .op_o(op), .acc_adr_o(acc_adr), .wmask_o(wmask)
    );

    sbs_array #(.AW(AW)) u_arr (
        .clk(clk), .rst(rst),
        .op_i(op), .adr_i(acc_adr), .wmask_i(wmask), .din_i(din_q),
        .rd_data_o(arr_data), .rd_vld_o(arr_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else begin
            out_vld_q <= arr_vld;
            if (arr_vld)
                out_q <= arr_data;
        end
    end

    assign rdata_o  = out_q;
    assign rvalid_o = out_vld_q & oe_i;

    a_r1_first_word: assert property (@(posedge clk) disable iff (rst)
        (astb_cpu_i && cs_pipe_i && cs_hi_i && cs_lo_i) |-> ##3 out_vld_q);

endmodule

// File: tb/test_sbsram.sv
`timescale 1ns/100ps
module test_sbsram;

    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [35:0]   wdata_i = '0;
    logic          cs_pipe_i = 1'b0, cs_hi_i = 1'b0, cs_lo_i = 1'b0;
    logic          astb_cpu_i = 1'b0, astb_ctl_i = 1'b0, adv_i = 1'b0;
    logic [3:0]    lane_we_i = '0;
    logic          lane_wen_i = 1'b0, wr_all_i = 1'b0, lin_i = 1'b0, oe_i = 1'b1;
    logic [35:0]   rdata_o;
    logic          rvalid_o;

    sbsram #(.AW(AW)) i_sbsram (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
        .cs_pipe_i(cs_pipe_i), .cs_hi_i(cs_hi_i), .cs_lo_i(cs_lo_i),
        .astb_cpu_i(astb_cpu_i), .astb_ctl_i(astb_ctl_i), .adv_i(adv_i),
        .lane_we_i(lane_we_i), .lane_wen_i(lane_wen_i), .wr_all_i(wr_all_i),
        .lin_i(lin_i), .oe_i(oe_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [35:0]   ref_mem [DEPTH];
    logic          m_act = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    logic          hv [4];
    logic [35:0]   hd [4];
    string         ht [4];
    int            step_n = 0;

    task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual vld=%0b data=%h expected vld=%0b data=%h",
                     req, act[36], act[35:0], exp[36], exp[35:0]);
        end
    endtask

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] k, input logic lin);
        return lin ? 2'(s + k) : (s ^ k);
    endfunction

    task automatic check_slot();
        int i;
        if (step_n >= 3) begin
            i = (step_n - 3) % 4;
            if (hv[i])
                check(ht[i], {rvalid_o, rdata_o}, {1'b1, hd[i]});
            else
                check(ht[i], {rvalid_o, 36'd0}, {1'b0, 36'd0});
        end
    endtask

    // drive one command at a negedge, model it, advance to next negedge
    task automatic step(input logic cpu, input logic ctl, input logic adv,
                        input logic [2:0] ce, input logic [AW-1:0] a,
                        input logic [35:0] d, input logic [3:0] we,
                        input logic bwe, input logic gw, input logic lin,
                        input string tag_ovr);
        logic cpu_ok, start, sel, rd, wr;
        logic [3:0] mask;
        logic [AW-1:0] acc;
        string tg;
        check_slot();
        astb_cpu_i = cpu; astb_ctl_i = ctl; adv_i = adv;
        cs_pipe_i = ce[2]; cs_hi_i = ce[1]; cs_lo_i = ce[0];
        addr_i = a; wdata_i = d; lane_we_i = we; lane_wen_i = bwe;
        wr_all_i = gw; lin_i = lin;
        cpu_ok = cpu & ce[2];
        start = cpu_ok | ctl;
        sel = &ce;
        mask = gw ? 4'hF : (bwe ? we : 4'h0);
        rd = 1'b0; wr = 1'b0;
        tg = "R3";
        if (start) begin
            m_act = sel; m_base = a; m_cnt = 2'd0;
            if (!sel) tg = "R9";
            else if (cpu_ok) begin rd = 1'b1; tg = (mask != 0) ? "R11" : "R1"; end
            else if (mask != 0) begin wr = 1'b1; tg = gw ? "R7" : "R6"; end
            else begin rd = 1'b1; tg = "R1"; end
        end else if (adv && m_act) begin
            m_cnt = m_cnt + 2'd1;
            if (mask != 0) begin wr = 1'b1; tg = gw ? "R7" : "R6"; end
            else begin rd = 1'b1; tg = lin ? "R5" : "R4"; end
        end else if (cpu && !ce[2]) tg = "R10";
        else if (adv) tg = "R9";
        if (tag_ovr != "") tg = tag_ovr;
        acc = {m_base[AW-1:2], exp_low(m_base[1:0], m_cnt, lin)};
        if (wr)
            for (int k = 0; k < 4; k++)
                if (mask[k]) ref_mem[acc][k*9 +: 9] = d[k*9 +: 9];
        hv[step_n % 4] = rd;
        hd[step_n % 4] = rd ? ref_mem[acc] : 36'd0;
        ht[step_n % 4] = tg;
        step_n++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(0, 0, 0, 3'b111, '0, '0, '0, 0, 0, 0, "R3");
    endtask

    task automatic oe_probe(input logic want_vld);
        logic v;
        logic [35:0] dd;
        v = rvalid_o; dd = rdata_o;
        check("R8", {v, 36'd0}, {want_vld, 36'd0});
        #0.5 oe_i = 1'b0;
        #0.5 check("R8", {rvalid_o, 36'd0}, {1'b0, 36'd0});
        oe_i = 1'b1;
        #0.5 check("R8", {rvalid_o, rdata_o}, {v, dd});
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", {rvalid_o, 36'd0}, {1'b0, 36'd0});
        rst = 1'b0;
        @(negedge clk);
        check("R1", {rvalid_o, 36'd0}, {1'b0, 36'd0});

        // fill the array with global writes
        for (int a = 0; a < DEPTH; a++)
            step(0, 1, 0, 3'b111, AW'(a), {4{9'(a * 7 + 3)}} ^ 36'h5A5A5A5A5, 4'h0, 0, 1, 0, "R7");

        // interleaved burst, start low bits 2
        step(1, 0, 0, 3'b111, 6'h16, '0, '0, 0, 0, 0, "R1");
        for (int k = 0; k < 3; k++) step(0, 0, 1, 3'b111, 6'h16, '0, '0, 0, 0, 0, "R4");
        oe_probe(1'b1);
        // linear burst, start low bits 3
        step(1, 0, 0, 3'b111, 6'h1B, '0, '0, 0, 0, 1, "R1");
        for (int k = 0; k < 3; k++) step(0, 0, 1, 3'b111, 6'h1B, '0, '0, 0, 0, 1, "R5");
        // counter hold: idle then continue
        step(1, 0, 0, 3'b111, 6'h29, '0, '0, 0, 0, 1, "R1");
        step(0, 0, 0, 3'b111, 6'h00, '0, '0, 0, 0, 1, "R3");
        step(0, 0, 1, 3'b111, 6'h00, '0, '0, 0, 0, 1, "R3");
        // address and enables ignored during advance
        step(1, 0, 0, 3'b111, 6'h20, '0, '0, 0, 0, 0, "R2");
        step(0, 0, 1, 3'b101, 6'h3F, '0, '0, 0, 0, 0, "R2");
        step(0, 0, 1, 3'b000, 6'h11, '0, '0, 0, 0, 0, "R2");
        // byte write then read back next cycle
        step(0, 1, 0, 3'b111, 6'h05, 36'hFFFFFFFFF, 4'b0101, 1, 0, 0, "R6");
        step(0, 1, 0, 3'b111, 6'h05, '0, '0, 0, 0, 0, "R12");
        step(0, 1, 0, 3'b111, 6'h06, 36'h123456789, 4'b1111, 0, 0, 0, "R6");
        step(0, 1, 0, 3'b111, 6'h06, '0, '0, 0, 0, 0, "R6");
        // processor start ignores write controls, advance honours them
        step(1, 0, 0, 3'b111, 6'h07, 36'hABCDEF012, '0, 0, 1, 1, "R11");
        step(0, 0, 1, 3'b111, 6'h07, 36'h0F0F0F0F0, '0, 0, 1, 1, "R11");
        step(0, 1, 0, 3'b111, 6'h07, '0, '0, 0, 0, 1, "R11");
        step(0, 1, 0, 3'b111, 6'h04, '0, '0, 0, 0, 1, "R11");
        // gated processor strobe, controller deselect, stray advance
        step(1, 0, 0, 3'b011, 6'h08, '0, '0, 0, 0, 0, "R10");
        step(0, 1, 0, 3'b011, 6'h08, '0, '0, 0, 0, 0, "R10");
        step(0, 0, 1, 3'b111, 6'h08, 36'h1, '0, 0, 1, 0, "R9");
        step(0, 1, 0, 3'b111, 6'h08, '0, '0, 0, 0, 0, "R9");
        step(0, 1, 0, 3'b110, 6'h09, 36'h2, '0, 0, 1, 0, "R9");
        step(0, 0, 1, 3'b111, 6'h09, '0, '0, 0, 0, 0, "R9");
        step(0, 1, 0, 3'b111, 6'h09, '0, '0, 0, 0, 0, "R9");
        step(0, 1, 0, 3'b111, 6'h0A, '0, '0, 0, 0, 0, "R9");
        idle(3);
        oe_probe(1'b0);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic cpu, ctl, adv, gw, bwe;
            logic [2:0] ce;
            r = int'($urandom % 16);
            cpu = (r < 4);
            ctl = (r >= 4 && r < 7);
            adv = (r >= 7 && r < 13);
            ce = 3'b111;
            if ($urandom % 8 == 0) ce[2] = 1'b0;
            if ($urandom % 12 == 0) ce[$urandom % 2] = 1'b0;
            gw = ($urandom % 6 == 0);
            bwe = ($urandom % 3 == 0);
            step(cpu, ctl, adv, ce, AW'($urandom), {4'($urandom), 32'($urandom)},
                 4'($urandom), bwe, gw, 1'($urandom), "");
        end
        idle(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule